// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block merges sixteen external level-sensitive interrupt lines into a single request line for a host processor. Every line is first brought into the local clock domain through a short flop chain. A line that is high while software has enabled it sets a sticky pending flag. The flag stays set after the line drops, until software rewrites the pending register.

Software reaches three words through a small memory-mapped port: an enable word, a pending word and a read-only word that mirrors the current synchronised line levels. Writes to the enable and pending words keep only the implemented bit positions. A pending write replaces the whole word, so one store can both raise and drop flags. The request line is high whenever a pending flag and its enable bit are both set.

Top module: `irq_sticky_agg`

## Requirements
- R1: After reset the enable, pending and level words all read zero and `irq_out` is low.
- R2: Each input passes through two clock flops. The level word at byte offset 0xB0 shows input n in bit n two rising edges after the input changes. It covers all sixteen inputs whatever the enable word holds.
- R3: If input n is seen high in the level word while enable bit n is set, pending bit n reads 1 after the next rising edge. It stays 1 after the input falls, until software writes the pending word.
- R4: A high input whose enable bit is clear never sets its pending bit.
- R5: A write to the enable or pending word stores the write data ANDed with 0x000FEEFF, so bits 8, 12 and 20 to 31 always read zero. Inputs 8 and 12 therefore can never latch.
- R6: A write to the pending word replaces its whole content, both setting and clearing bits.
- R7: `irq_out` is high exactly when the AND of pending and enable is nonzero. It reflects a register write from the clock edge that stores it.
- R8: The enable word sits at byte offset 0xC0 and the pending word at byte offset 0xD0. Both read back what was stored.
- R9: Writes to the level word or to any unmapped offset change no register. Reads of unmapped offsets return zero.
- R10: When a pending write and a hardware set of bit n fall on the same edge, bit n ends up 1 whatever value was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | External level interrupt lines, asynchronous |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write when high |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address, zero when not selected |
| irq_out | output | 1 | Aggregated interrupt request to the host |

## Verification
On every cycle, the embedded properties check these behaviours:
- Unimplemented bits stay zero.
- Pending flags only rise when enabled and never fall without a software write.
- A hardware set wins over a simultaneous pending write.
- The two enable strobes never fire together.
- The level word lags the inputs by exactly two edges.

The offsets and read-back values need the directed scenarios in the bench, as do the replace-style write semantics, the request line following register writes and the silence of writes to the level word or unmapped offsets.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam logic [7:0]  OFF_LEVEL  = 8'hB0;
   localparam logic [7:0]  OFF_ENABLE = 8'hC0;
   localparam logic [7:0]  OFF_PEND   = 8'hD0;

   localparam logic [31:0] IMPL_MASK_DEFAULT = 32'h000F_EEFF;

   typedef enum logic [1:0] {
      WSEL_NONE   = 2'd0,
      WSEL_ENABLE = 2'd1,
      WSEL_PEND   = 2'd2,
      WSEL_LEVEL  = 2'd3
   } word_sel_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES == 1) begin : g_bad_stages
         $error("irq_sync: STAGES must be 0 or at least 2");
      end

      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= async_i;
               for (int s = 1; s < STAGES; s++) begin
                  chain_q[s] <= chain_q[s-1];
               end
            end
         end

         assign sync_o = chain_q[STAGES-1];

         if (STAGES == 2) begin : g_lag_check
            logic [1:0] age_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)             age_q <= 2'd0;
               else if (age_q != 2'd2) age_q <= age_q + 2'd1;
            end

            AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
               (age_q == 2'd2) |-> (sync_o == $past(async_i, 2))); // R2
         end
      end
   endgenerate

endmodule

// File: rtl/irq_regport.sv
module irq_regport
   import irq_agg_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_IRQ  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] en_i,
   input  logic [DATA_W-1:0] pend_i,
   input  logic [N_IRQ-1:0]  level_i,
   output logic              wr_en_o,
   output logic              wr_pend_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);

   word_sel_e         hit;
   logic [DATA_W-1:0] level_ext;

   always_comb begin
      level_ext = '0;
      level_ext[N_IRQ-1:0] = level_i;
   end

   always_comb begin
      unique case (addr_i)
         A_ENABLE: hit = WSEL_ENABLE;
         A_PEND:   hit = WSEL_PEND;
         A_LEVEL:  hit = WSEL_LEVEL;
         default:  hit = WSEL_NONE;
      endcase
   end

   assign wr_en_o   = sel_i && wr_i && (hit == WSEL_ENABLE);
   assign wr_pend_o = sel_i && wr_i && (hit == WSEL_PEND);

   always_comb begin
      rdata_o = '0;
      if (sel_i) begin
         case (hit)
            WSEL_ENABLE: rdata_o = en_i;
            WSEL_PEND:   rdata_o = pend_i;
            WSEL_LEVEL:  rdata_o = level_ext;
            default:     rdata_o = '0;
         endcase
      end
   end

   AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en_o, wr_pend_o})); // R9

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned       N_IRQ     = 16,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  level_i,
   input  logic              wr_en_i,
   input  logic              wr_pend_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] en_o,
   output logic [DATA_W-1:0] pend_o,
   output logic              irq_o
);

   logic [DATA_W-1:0] en_q, pend_q, hw_set, pend_d;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_set
         if (gi < N_IRQ && IMPL_MASK[gi]) begin : g_live
            assign hw_set[gi] = level_i[gi] & en_q[gi];
         end else begin : g_dead
            assign hw_set[gi] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      if (wr_pend_i) pend_d = (wdata_i & IMPL_MASK) | hw_set;
      else           pend_d = pend_q | hw_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         if (wr_en_i) en_q <= wdata_i & IMPL_MASK;
         pend_q <= pend_d;
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign irq_o  = |(pend_q & en_q);

   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & ~IMPL_MASK) == '0) && ((pend_q & ~IMPL_MASK) == '0)); // R5

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pend_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pend_i |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0)); // R4

   AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend_i |=> ((pend_q & $past(hw_set)) == $past(hw_set))); // R10

endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned       N_IRQ       = 16,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] IMPL_MASK   = DATA_W'(IMPL_MASK_DEFAULT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_in,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);

   generate
      if (N_IRQ == 0 || N_IRQ > DATA_W) begin : g_bad_width
         $error("irq_sticky_agg: N_IRQ must be 1..DATA_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("irq_sticky_agg: ADDR_W must cover the register offsets");
      end
   endgenerate

   logic [N_IRQ-1:0]  level;
   logic [DATA_W-1:0] en_w, pend_w;
   logic              wr_en, wr_pend;

   irq_sync #(
      .WIDTH  (N_IRQ),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_in),
      .sync_o  (level)
   );

   irq_regport #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .N_IRQ  (N_IRQ)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (reg_sel),
      .wr_i      (reg_wr),
      .addr_i    (reg_addr),
      .en_i      (en_w),
      .pend_i    (pend_w),
      .level_i   (level),
      .wr_en_o   (wr_en),
      .wr_pend_o (wr_pend),
      .rdata_o   (reg_rdata)
   );

   irq_pend_bank #(
      .N_IRQ     (N_IRQ),
      .DATA_W    (DATA_W),
      .IMPL_MASK (IMPL_MASK)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (level),
      .wr_en_i   (wr_en),
      .wr_pend_i (wr_pend),
      .wdata_i   (reg_wdata),
      .en_o      (en_w),
      .pend_o    (pend_w),
      .irq_o     (irq_out)
   );

   AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq_out); // R1

endmodule

// File: tb/irq_sticky_agg_test.sv
module irq_sticky_agg_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   irq_sticky_agg uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      reg_sel = 1'b0;
   endtask

   task automatic drive_in(input logic [15:0] v);
      @(negedge clk);
      irq_in = v;
   endtask

   task automatic clean();
      drive_in(16'h0000);
      cycles(3);
      wr(8'hC0, 32'h0);
      wr(8'hD0, 32'h0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'hC0, d); chk("R1 enable", d, 32'h0);
      rd(8'hD0, d); chk("R1 pending", d, 32'h0);
      rd(8'hB0, d); chk("R1 level", d, 32'h0);
      chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(8'hC0, 32'hFFFF_FFFF);
      rd(8'hC0, d); chk("R5 R8 enable masked", d, 32'h000F_EEFF);
      chk("R7 no pending yet", {31'h0, irq_out}, 32'h0);
      wr(8'hD0, 32'hFFFF_FFFF);
      rd(8'hD0, d); chk("R5 R8 pending masked", d, 32'h000F_EEFF);
      chk("R7 out after pend write", {31'h0, irq_out}, 32'h1);
      wr(8'hD0, 32'h0000_0005);
      rd(8'hD0, d); chk("R6 pending replaced", d, 32'h0000_0005);
      wr(8'hD0, 32'h0);
      chk("R7 out drops", {31'h0, irq_out}, 32'h0);
      wr(8'hD0, 32'h0001_0000);
      chk("R7 bit16 enabled", {31'h0, irq_out}, 32'h1);
      wr(8'hC0, 32'h0);
      chk("R7 out after enable cleared", {31'h0, irq_out}, 32'h0);
      clean();
   endtask

   task automatic t_sync();
      logic [31:0] d;
      drive_in(16'h0001);
      @(negedge clk);
      rd(8'hB0, d); chk("R2 level after one edge", d, 32'h0);
      @(negedge clk);
      rd(8'hB0, d); chk("R2 level after two edges", d, 32'h1);
      drive_in(16'h1100);
      cycles(2);
      rd(8'hB0, d); chk("R2 level unmasked bits", d, 32'h1100);
      rd(8'hD0, d); chk("R4 nothing enabled", d, 32'h0);
      clean();
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      wr(8'hC0, 32'h0000_0004);
      drive_in(16'h0004);
      cycles(2);
      rd(8'hD0, d); chk("R3 not yet latched", d, 32'h0);
      @(negedge clk);
      rd(8'hD0, d); chk("R3 latched", d, 32'h4);
      chk("R7 out on latch", {31'h0, irq_out}, 32'h1);
      drive_in(16'h0000);
      cycles(4);
      rd(8'hD0, d); chk("R3 sticky after fall", d, 32'h4);
      wr(8'hD0, 32'h0);
      rd(8'hD0, d); chk("R6 cleared by write", d, 32'h0);
      chk("R7 out low after clear", {31'h0, irq_out}, 32'h0);
      clean();
   endtask

   task automatic t_holes();
      logic [31:0] d;
      wr(8'hC0, 32'h0000_FFFF);
      drive_in(16'h1100);
      cycles(5);
      rd(8'hD0, d); chk("R5 inputs 8 and 12 never latch", d, 32'h0);
      chk("R5 out stays low", {31'h0, irq_out}, 32'h0);
      clean();
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      drive_in(16'h0010);
      cycles(5);
      rd(8'hD0, d); chk("R4 disabled input ignored", d, 32'h0);
      wr(8'hC0, 32'h0000_0010);
      @(negedge clk);
      rd(8'hD0, d); chk("R3 latch once enabled", d, 32'h10);
      chk("R7 out after enable", {31'h0, irq_out}, 32'h1);
      clean();
   endtask

   task automatic t_ignore();
      logic [31:0] d;
      wr(8'hC0, 32'h0000_0003);
      wr(8'hD0, 32'h0000_0002);
      drive_in(16'h0100);
      cycles(2);
      wr(8'hB0, 32'h0000_FFFF);
      rd(8'hB0, d); chk("R9 level write ignored", d, 32'h0100);
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h44, d); chk("R9 unmapped reads zero", d, 32'h0);
      rd(8'hC0, d); chk("R9 enable untouched", d, 32'h3);
      rd(8'hD0, d); chk("R9 pending untouched", d, 32'h2);
      clean();
   endtask

   task automatic t_conflict();
      logic [31:0] d;
      wr(8'hC0, 32'h0000_0002);
      drive_in(16'h0002);
      cycles(3);
      wr(8'hD0, 32'h0);
      rd(8'hD0, d); chk("R10 hw set beats clear", d, 32'h2);
      wr(8'hD0, 32'h1);
      rd(8'hD0, d); chk("R10 merge with written bits", d, 32'h3);
      drive_in(16'h0000);
      cycles(3);
      wr(8'hD0, 32'h0);
      rd(8'hD0, d); chk("R6 clear once input low", d, 32'h0);
      clean();
   endtask

   initial begin
      cycles(3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_regs();
      t_sync();
      t_sticky();
      t_holes();
      t_disabled();
      t_ignore();
      t_conflict();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule